// File: doc/BRIEF.md
# Security State Controller

This block decides, after every reset, how much trust the surrounding cipher engine may place in its key material. It starts in an initial state, waits while the key memory wipes itself, and then sits in a health-check state. From there, software must write a fixed three-step pattern to a small sequence checker. A correct pattern promotes the block to the secure state, in which the secret key is valid. Any deviation from the pattern drops the block to the non-secure state, in which only a default key may be used.

A tamper input and a software alarm bit in the command register each force the block into a fail state. The fail state is a permanent lockout: the cipher memory is disabled, and only a reset clears it. Entry into the fail state raises an interrupt, which software can enable, clear and lock against further change.

Software sees the state, the command bits and the stored sequence values through a simple register bus. Writes take effect on the clock edge on which the write enable is sampled. Read data is registered and comes back one cycle later, together with a valid strobe.

Top module: `smMonitor`

## Requirements
- R1: On reset the state is START (0x00). On the first clock after reset it moves to ZEROIZE (0x05). The state is read in bits 4:0 of the status register at offset 0x1000; the other bits read 0. Read data and `busRdValid` appear one cycle after `busRdEn`. The remaining codes are HEALTH 0x06, FAIL 0x09, SECURE 0x0A and NONSECURE 0x0C.
- R2: The block stays in ZEROIZE while `zeroizeDone` is low. It enters HEALTH on the first clock edge at which `zeroizeDone` is high.
- R3: In HEALTH, a write of 0xAAAA to sequence-start (0x1008), then 0x5555 to sequence-end (0x100C), then 0x5555 to sequence-check (0x1010) moves the block to SECURE. `secretKeyValid` is high in SECURE only.
- R4: In HEALTH, the block moves to NONSECURE when the three writes come in order but the start value is not 0xAAAA, the end value is not 0x5555, or the check value differs from the end value.
- R5: In HEALTH, a sequence-end or sequence-check write before its predecessor, or a second sequence-start write, moves the block to NONSECURE.
- R6: Outside HEALTH, writes to the sequence registers change neither the state nor the stored values. Sequence-start and sequence-end read back their stored values; sequence-check reads 0.
- R7: A high `tamperAlarm` moves any state to FAIL on the next edge. `memEnable` is high only in SECURE and NONSECURE.
- R8: Writing the command register (0x1004) with bit 0 set moves any state to FAIL.
- R9: FAIL is left only by reset. Sequence writes and `zeroizeDone` have no effect on it.
- R10: Entering FAIL sets an interrupt-pending flag. `irqOut` is the pending flag ANDed with the enable in command bit 1. A command write with bit 3 set clears the pending flag.
- R11: A command write with bit 4 set sets a lock until reset. While the lock is set, command writes do not change the enable bit. Command reads return the enable in bit 1 and the lock in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 13 | Byte offset within the block space |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| zeroizeDone | input | 1 | Key memory wipe finished |
| tamperAlarm | input | 1 | Combined tamper sensor alarm |
| secretKeyValid | output | 1 | Secret key may be used |
| memEnable | output | 1 | Cipher memory operative |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things: fail is never left, an alarm always lands in fail, secure is entered only from health, and the state holds in zeroize until the wipe completes. They also check that the interrupt flag rises only with fail and that the lock freezes the enable bit. Whether a given write pattern yields secure or non-secure depends on data values and write order, so only the bench's scenarios can show it. The same holds for the readback of ignored writes and the interrupt clear and lock sequences.

// File: rtl/smPkg.sv
package smPkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 13'h1000;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 13'h1004;
  localparam logic [ADDR_W-1:0] OFF_START  = 13'h1008;
  localparam logic [ADDR_W-1:0] OFF_END    = 13'h100C;
  localparam logic [ADDR_W-1:0] OFF_CHECK  = 13'h1010;

  localparam int CMD_ALARM = 0;
  localparam int CMD_IRQEN = 1;
  localparam int CMD_CLRIRQ = 3;
  localparam int CMD_LOCK = 4;

  typedef enum logic [4:0] {
    ST_START  = 5'h00,
    ST_ZERO   = 5'h05,
    ST_HEALTH = 5'h06,
    ST_FAIL   = 5'h09,
    ST_SECURE = 5'h0A,
    ST_NONSEC = 5'h0C
  } smState_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_STARTED,
    PH_ENDED
  } seqPhase_t;

  // datapath -> control
  typedef struct packed {
    logic wrStart;
    logic wrEnd;
    logic wrCheck;
    logic swAlarm;
    logic startOk;
    logic endOk;
    logic checkOk;
  } seqEvt_t;

  // control -> datapath
  typedef struct packed {
    logic captureEn;
    logic enterFail;
  } ctrlStb_t;
endpackage

// File: rtl/smControl.sv
module smControl
  import smPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tamperAlarm,
  input  logic     zeroizeDone,
  input  seqEvt_t  evt,
  output ctrlStb_t stb,
  output smState_t stateQ,
  output logic     secretKeyValid,
  output logic     memEnable
);
  smState_t  stateD;
  seqPhase_t phaseQ, phaseD;
  logic      alarm;

  assign alarm = tamperAlarm | evt.swAlarm;

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    if (alarm) begin
      stateD = ST_FAIL;
    end else begin
      case (stateQ)
        ST_START: stateD = ST_ZERO;
        ST_ZERO: if (zeroizeDone) stateD = ST_HEALTH;
        ST_HEALTH: begin
          if (evt.wrStart) begin
            if (phaseQ == PH_IDLE) phaseD = PH_STARTED;
            else stateD = ST_NONSEC;
          end else if (evt.wrEnd) begin
            if (phaseQ == PH_STARTED) phaseD = PH_ENDED;
            else stateD = ST_NONSEC;
          end else if (evt.wrCheck) begin
            if (phaseQ == PH_ENDED && evt.startOk && evt.endOk && evt.checkOk)
              stateD = ST_SECURE;
            else
              stateD = ST_NONSEC;
          end
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_START;
      phaseQ <= PH_IDLE;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  assign stb.captureEn = (stateQ == ST_HEALTH);
  assign stb.enterFail = alarm && (stateQ != ST_FAIL);

  assign secretKeyValid = (stateQ == ST_SECURE);
  assign memEnable      = (stateQ == ST_SECURE) || (stateQ == ST_NONSEC);

  AST_START_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_START && !tamperAlarm && !evt.swAlarm) |=> (stateQ == ST_ZERO)); // R1
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ZERO && !zeroizeDone && !tamperAlarm && !evt.swAlarm) |=> (stateQ == ST_ZERO)); // R2
  AST_SECURE_FROM_HEALTH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SECURE && $past(stateQ) != ST_SECURE) |-> ($past(stateQ) == ST_HEALTH)); // R3
  AST_TAMPER_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    tamperAlarm |=> (stateQ == ST_FAIL)); // R7
  AST_SWALARM_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    evt.swAlarm |=> (stateQ == ST_FAIL)); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FAIL) |=> (stateQ == ST_FAIL)); // R9
endmodule

// File: rtl/smDatapath.sv
module smDatapath
  import smPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [15:0] START_KEY = 16'hAAAA,
  parameter logic [15:0] END_KEY   = 16'h5555
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busRdData,
  output logic          busRdValid,
  input  ctrlStb_t      stb,
  input  smState_t      stateIn,
  output seqEvt_t       evt,
  output logic          irqOut
);
  localparam logic [DW-1:0] START_EXP = DW'(START_KEY);
  localparam logic [DW-1:0] END_EXP   = DW'(END_KEY);

  logic [DW-1:0] seqStartQ, seqEndQ;
  logic cmdWr, irqEnQ, lockQ, irqPendQ;
  logic [DW-1:0] rdMux;

  assign cmdWr       = busWrEn && (busAddr == AW'(OFF_CMD));
  assign evt.wrStart = busWrEn && (busAddr == AW'(OFF_START));
  assign evt.wrEnd   = busWrEn && (busAddr == AW'(OFF_END));
  assign evt.wrCheck = busWrEn && (busAddr == AW'(OFF_CHECK));
  assign evt.swAlarm = cmdWr && busWrData[CMD_ALARM];
  assign evt.startOk = (seqStartQ == START_EXP);
  assign evt.endOk   = (seqEndQ == END_EXP);
  assign evt.checkOk = (busWrData == seqEndQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqStartQ <= '0;
      seqEndQ   <= '0;
    end else if (stb.captureEn) begin
      if (evt.wrStart) seqStartQ <= busWrData;
      if (evt.wrEnd)   seqEndQ   <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ   <= 1'b0;
      lockQ    <= 1'b0;
      irqPendQ <= 1'b0;
    end else begin
      if (cmdWr && !lockQ) irqEnQ <= busWrData[CMD_IRQEN];
      if (cmdWr && busWrData[CMD_LOCK]) lockQ <= 1'b1;
      if (stb.enterFail) irqPendQ <= 1'b1;
      else if (cmdWr && busWrData[CMD_CLRIRQ]) irqPendQ <= 1'b0;
    end
  end

  assign irqOut = irqPendQ && irqEnQ;

  always_comb begin
    rdMux = '0;
    if (busAddr == AW'(OFF_STATUS)) rdMux = DW'(stateIn);
    else if (busAddr == AW'(OFF_CMD)) begin
      rdMux[CMD_IRQEN] = irqEnQ;
      rdMux[CMD_LOCK]  = lockQ;
    end
    else if (busAddr == AW'(OFF_START)) rdMux = seqStartQ;
    else if (busAddr == AW'(OFF_END)) rdMux = seqEndQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdData <= rdMux;
    end
  end

  AST_IRQ_ON_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPendQ) |-> (stateIn == ST_FAIL)); // R10
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && $past(lockQ)) |-> $stable(irqEnQ)); // R11
  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (stateIn != ST_HEALTH) |=> $stable(seqStartQ) && $stable(seqEndQ)); // R6
endmodule

// File: rtl/smMonitor.sv
module smMonitor
  import smPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busRdData,
  output logic          busRdValid,
  input  logic          zeroizeDone,
  input  logic          tamperAlarm,
  output logic          secretKeyValid,
  output logic          memEnable,
  output logic          irqOut
);
  seqEvt_t  evt;
  ctrlStb_t stb;
  smState_t stateQ;

  smControl uCtrl (
    .clk(clk), .rstN(rstN), .tamperAlarm(tamperAlarm), .zeroizeDone(zeroizeDone),
    .evt(evt), .stb(stb), .stateQ(stateQ),
    .secretKeyValid(secretKeyValid), .memEnable(memEnable)
  );

  smDatapath #(.AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .stb(stb), .stateIn(stateQ), .evt(evt),
    .irqOut(irqOut)
  );
endmodule

// File: tb/tb_smMonitor.sv
module tb_smMonitor;
  localparam logic [12:0] A_STAT = 13'h1000, A_CMD = 13'h1004,
                          A_START = 13'h1008, A_END = 13'h100C, A_CHK = 13'h1010;
  localparam logic [31:0] S_START = 32'h00, S_ZERO = 32'h05, S_HEALTH = 32'h06,
                          S_FAIL = 32'h09, S_SEC = 32'h0A, S_NONSEC = 32'h0C;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, busRdEn = 1'b0;
  logic [12:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic busRdValid, zeroizeDone = 1'b0, tamperAlarm = 1'b0;
  logic secretKeyValid, memEnable, irqOut;

  int checks = 0, failures = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  smMonitor dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .zeroizeDone(zeroizeDone), .tamperAlarm(tamperAlarm),
    .secretKeyValid(secretKeyValid), .memEnable(memEnable), .irqOut(irqOut)
  );

  // monitor: pops the scoreboard as read data comes back
  always @(negedge clk) begin
    if (busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data: actual %h expected none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          failures++;
          $display("FAIL %s: read actual %h expected %h", t, busRdData, e);
        end
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [12:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic pin(input string t, input logic act, input logic e);
    @(negedge clk);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0; zeroizeDone = 1'b0; tamperAlarm = 1'b0;
    busWrEn = 1'b0; busRdEn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1; busRdEn = 1'b1; busAddr = A_STAT;
    expQ.push_back(S_START); tagQ.push_back("R1 reset state");
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic toHealth();
    @(posedge clk); #1;
    zeroizeDone = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 / R2: reset, zeroize wait, ignored writes (R6)
    doReset();
    rdExp(A_STAT, S_ZERO, "R1 zeroize after reset");
    repeat (4) @(posedge clk);
    rdExp(A_STAT, S_ZERO, "R2 holds in zeroize");
    pin("R7 memEnable low in zeroize", memEnable, 1'b0);
    wr(A_START, 32'h1234);
    rdExp(A_START, 32'h0, "R6 start ignored outside health");
    rdExp(A_STAT, S_ZERO, "R6 state unchanged");
    toHealth();
    rdExp(A_STAT, S_HEALTH, "R2 health after zeroize done");

    // R3: correct sequence
    wr(A_START, 32'hAAAA);
    wr(A_END, 32'h5555);
    wr(A_CHK, 32'h5555);
    rdExp(A_STAT, S_SEC, "R3 secure");
    pin("R3 secretKeyValid", secretKeyValid, 1'b1);
    pin("R7 memEnable secure", memEnable, 1'b1);
    wr(A_START, 32'h1111);
    rdExp(A_START, 32'hAAAA, "R6 start readback after secure");
    rdExp(A_CHK, 32'h0, "R6 check reads zero");
    rdExp(A_STAT, S_SEC, "R6 still secure");

    // R4: bad check value
    doReset(); toHealth();
    wr(A_START, 32'hAAAA); wr(A_END, 32'h5555); wr(A_CHK, 32'h5554);
    rdExp(A_STAT, S_NONSEC, "R4 check mismatch");
    pin("R4 secretKeyValid low", secretKeyValid, 1'b0);
    pin("R7 memEnable nonsecure", memEnable, 1'b1);

    // R4: bad start value
    doReset(); toHealth();
    wr(A_START, 32'h1234); wr(A_END, 32'h5555); wr(A_CHK, 32'h5555);
    rdExp(A_STAT, S_NONSEC, "R4 start mismatch");

    // R4: bad end value, check equal to it
    doReset(); toHealth();
    wr(A_START, 32'hAAAA); wr(A_END, 32'h7777); wr(A_CHK, 32'h7777);
    rdExp(A_STAT, S_NONSEC, "R4 end mismatch");

    // R5: order errors
    doReset(); toHealth();
    wr(A_END, 32'h5555);
    rdExp(A_STAT, S_NONSEC, "R5 end first");
    doReset(); toHealth();
    wr(A_START, 32'hAAAA); wr(A_CHK, 32'h5555);
    rdExp(A_STAT, S_NONSEC, "R5 check before end");
    doReset(); toHealth();
    wr(A_START, 32'hAAAA); wr(A_START, 32'hAAAA);
    rdExp(A_STAT, S_NONSEC, "R5 repeated start");

    // R7 / R10 / R9: tamper in health with irq enabled
    doReset(); toHealth();
    wr(A_CMD, 32'h2);
    pin("R10 no irq before fail", irqOut, 1'b0);
    @(posedge clk); #1; tamperAlarm = 1'b1;
    @(posedge clk); #1; tamperAlarm = 1'b0;
    rdExp(A_STAT, S_FAIL, "R7 tamper to fail");
    pin("R10 irq raised", irqOut, 1'b1);
    pin("R7 memEnable low in fail", memEnable, 1'b0);
    wr(A_CMD, 32'hA);
    pin("R10 irq cleared", irqOut, 1'b0);
    wr(A_START, 32'hAAAA); wr(A_END, 32'h5555); wr(A_CHK, 32'h5555);
    rdExp(A_STAT, S_FAIL, "R9 fail sticky");
    rdExp(A_CMD, 32'h2, "R11 cmd readback enable");

    // R7: tamper during zeroize
    doReset();
    @(posedge clk); #1; tamperAlarm = 1'b1;
    @(posedge clk); #1; tamperAlarm = 1'b0;
    zeroizeDone = 1'b1;
    repeat (2) @(posedge clk);
    rdExp(A_STAT, S_FAIL, "R9 zeroizeDone ignored in fail");

    // R8: software alarm from secure
    doReset(); toHealth();
    wr(A_START, 32'hAAAA); wr(A_END, 32'h5555); wr(A_CHK, 32'h5555);
    wr(A_CMD, 32'h1);
    rdExp(A_STAT, S_FAIL, "R8 software alarm");
    pin("R8 secretKeyValid dropped", secretKeyValid, 1'b0);
    pin("R10 irq masked when disabled", irqOut, 1'b0);

    // R11: lock behaviour
    doReset();
    wr(A_CMD, 32'h2); wr(A_CMD, 32'h0);
    rdExp(A_CMD, 32'h0, "R11 enable writable unlocked");
    wr(A_CMD, 32'h12); wr(A_CMD, 32'h0);
    rdExp(A_CMD, 32'h12, "R11 lock freezes enable");

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R1 reads missing: actual %0d pending expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule